// File: doc/BRIEF.md
# Quad Cycle Compression Dispatcher

This block turns one wide SIMD instruction into a series of 4-lane operations for a narrow ALU. The instruction may be 8, 16 or 32 threads wide. Thread slots are split into quads of four. A quad with no active thread costs no cycle. The number of cycles an instruction takes therefore follows its execution mask, not its nominal width.

In packing mode the block does not keep quads fixed. It collects the active threads in ascending thread order and fills whole 4-lane groups with them. For each lane it reports the source thread index, so the operand fetch can route the data and the writeback can apply the inverse mapping. Packing has a fixed rule: the order is kept and groups fill from lane 0 upward. This rule is simple but does not cover every possible permutation.

An issuing stage raises `start_i` while `ready_o` is high. It then follows `issue_o`, `quad_o`, `lanes_o` and `sel_o` until `done_o`.

Top module: `quad_dispatch`

## Requirements
- R1: While reset is held and after it is released, `ready_o` is 1, and `issue_o` and `done_o` are 0.
- R2: The width code limits which mask bits count: code 0 uses bits 7:0, code 1 uses bits 15:0, and code 2 or 3 uses bits 31:0. Mask bits outside that range have no effect on any output.
- R3: In quad mode, the non-empty quads are issued in ascending order, one per cycle, with no idle cycle between them. For quad k, `quad_o` = k and `lanes_o` = mask bits 4k+3..4k, with lane j on bit 4k+j. `issue_o` never comes with an all-zero `lanes_o`.
- R4: A quad whose four mask bits are all zero is skipped and costs no cycle. For example, width code 1 with mask 0xF0F0 gives exactly two operations, quads 1 and 3.
- R5: In quad mode, lane j's 5-bit field `sel_o[5j+4:5j]` equals 4·`quad_o`+j for every lane, whether the lane is active or not.
- R6: In packing mode, the n active threads are issued in ceil(n/4) cycles. Group g has `quad_o` = g. Lane j carries the (4g+j)-th active thread in ascending index order, with its index in `sel_o`. `lanes_o` is set from lane 0 upward, and unused lanes read select 0.
- R7: The first operation appears in the second cycle after the accepting clock edge. `done_o` is high for one cycle, in the same cycle as the last operation.
- R8: If the effective mask is all zero, no operation is issued. `done_o` is high in the cycle just after the accepting edge.
- R9: `ready_o` is low from the accepting edge until the cycle of `done_o`. A `start_i` raised while `ready_o` is low is ignored. Once an instruction is done, nothing is issued until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New instruction request, taken when `ready_o` is high |
| width_i | input | 2 | SIMD width code: 0 = 8, 1 = 16, 2 or 3 = 32 threads |
| swizzle_i | input | 1 | 1 selects packing mode, 0 selects quad mode |
| exec_mask_i | input | 32 | Execution mask, bit i = thread i |
| ready_o | output | 1 | Block idle, able to take an instruction |
| issue_o | output | 1 | A 4-lane operation is present this cycle |
| quad_o | output | 3 | Quad index (quad mode) or group ordinal (packing mode) |
| lanes_o | output | 4 | Active lanes of the current operation |
| sel_o | output | 20 | Source thread index per lane, 5 bits per lane, lane 0 lowest |
| done_o | output | 1 | Instruction finished this cycle |

## Verification
Some rules are checked on every cycle:
- No operation has empty lanes.
- Quad indices within one instruction rise strictly.
- Quad-mode selects are the identity mapping.
- Packed groups fill lanes from lane 0 with strictly ascending thread indices.
- Done never appears while busy.
- Nothing issues from idle without a start.
- A done without an operation only follows an accept one cycle earlier.

Other behaviour can only be shown by the bench's scenarios:
- The exact set of quads or groups for a given mask.
- The cut-off of mask bits by the width code.
- The cycle count.
- The position of done.
- That a start raised during a run has no effect.

// File: rtl/qdisp_pkg.sv
package qdisp_pkg;

    typedef enum logic {
        QD_IDLE = 1'b0,
        QD_RUN  = 1'b1
    } qd_state_e;

    // threads covered by width code 0; each code step doubles it
    localparam int QD_BASE_THREADS = 8;

endpackage

// File: rtl/qdisp_quad_pick.sv
module qdisp_quad_pick #(
    parameter int LANES = 4,
    parameter int QUADS = 8
) (
    input  logic [LANES*QUADS-1:0] mask_i,
    output logic                   found_o,
    output logic [((QUADS > 1) ? $clog2(QUADS) : 1)-1:0] idx_o,
    output logic [LANES-1:0]       bits_o,
    output logic [LANES*QUADS-1:0] rest_o
);
    localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1;

    logic [QUADS-1:0] nz;

    genvar q;
    generate
        for (q = 0; q < QUADS; q++) begin : g_nz
            assign nz[q] = |mask_i[q*LANES +: LANES];
        end
    endgenerate

    // lowest non-empty quad wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = QUADS - 1; k >= 0; k--) begin
            if (nz[k]) begin
                found_o = 1'b1;
                idx_o   = QW'(k);
            end
        end
    end

    always_comb begin
        bits_o = mask_i[idx_o*LANES +: LANES];
        rest_o = mask_i;
        rest_o[idx_o*LANES +: LANES] = '0;
    end

endmodule

// File: rtl/qdisp_pack_pick.sv
module qdisp_pack_pick #(
    parameter int LANES   = 4,
    parameter int THREADS = 32,
    parameter int TW      = 5
) (
    input  logic [THREADS-1:0]         mask_i,
    output logic [LANES-1:0]           valid_o,
    output logic [LANES-1:0][TW-1:0]   sel_o,
    output logic [THREADS-1:0]         rest_o
);
    logic [THREADS-1:0] rem;
    logic               hit;

    // take the LANES lowest set bits, one per lane, in ascending order
    always_comb begin
        rem     = mask_i;
        valid_o = '0;
        sel_o   = '0;
        hit     = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            hit = 1'b0;
            for (int i = 0; i < THREADS; i++) begin
                if (!hit && rem[i]) begin
                    hit        = 1'b1;
                    valid_o[j] = 1'b1;
                    sel_o[j]   = TW'(i);
                    rem[i]     = 1'b0;
                end
            end
        end
        rest_o = rem;
    end

endmodule

// File: rtl/quad_dispatch.sv
module quad_dispatch
    import qdisp_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_THREADS = 32
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start_i,
    input  logic [1:0]                                  width_i,
    input  logic                                        swizzle_i,
    input  logic [MAX_THREADS-1:0]                      exec_mask_i,
    output logic                                        ready_o,
    output logic                                        issue_o,
    output logic [((MAX_THREADS/LANES > 1) ? $clog2(MAX_THREADS/LANES) : 1)-1:0] quad_o,
    output logic [LANES-1:0]                            lanes_o,
    output logic [LANES*((MAX_THREADS > 1) ? $clog2(MAX_THREADS) : 1)-1:0] sel_o,
    output logic                                        done_o
);
    localparam int QUADS = MAX_THREADS / LANES;
    localparam int QW    = (QUADS > 1) ? $clog2(QUADS) : 1;
    localparam int TW    = (MAX_THREADS > 1) ? $clog2(MAX_THREADS) : 1;

    typedef struct packed {
        qd_state_e                st;
        logic                     swz;
        logic [MAX_THREADS-1:0]   pend;
        logic [QW-1:0]            grp;
        logic                     iss;
        logic [QW-1:0]            qidx;
        logic [LANES-1:0]         lmask;
        logic [LANES-1:0][TW-1:0] sel;
        logic                     done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    // width code -> mask of counted threads
    logic [MAX_THREADS-1:0] width_mask;
    always_comb begin
        int cnt;
        cnt = QD_BASE_THREADS << width_i;
        if (cnt > MAX_THREADS) cnt = MAX_THREADS;
        for (int i = 0; i < MAX_THREADS; i++) begin
            width_mask[i] = (i < cnt);
        end
    end

    logic                     qp_found;
    logic [QW-1:0]            qp_idx;
    logic [LANES-1:0]         qp_bits;
    logic [MAX_THREADS-1:0]   qp_rest;

    qdisp_quad_pick #(
        .LANES (LANES),
        .QUADS (QUADS)
    ) quad_pick_i (
        .mask_i  (ctx_q.pend),
        .found_o (qp_found),
        .idx_o   (qp_idx),
        .bits_o  (qp_bits),
        .rest_o  (qp_rest)
    );

    logic [LANES-1:0]         pk_valid;
    logic [LANES-1:0][TW-1:0] pk_sel;
    logic [MAX_THREADS-1:0]   pk_rest;

    qdisp_pack_pick #(
        .LANES   (LANES),
        .THREADS (MAX_THREADS),
        .TW      (TW)
    ) pack_pick_i (
        .mask_i  (ctx_q.pend),
        .valid_o (pk_valid),
        .sel_o   (pk_sel),
        .rest_o  (pk_rest)
    );

    // identity lane selects for the quad being issued
    logic [LANES-1:0][TW-1:0] ident_sel;
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            ident_sel[j] = TW'(int'(qp_idx) * LANES + j);
        end
    end

    always_comb begin
        logic [MAX_THREADS-1:0] eff;
        ctx_d      = ctx_q;
        ctx_d.iss  = 1'b0;
        ctx_d.done = 1'b0;
        eff        = exec_mask_i & width_mask;
        case (ctx_q.st)
            QD_IDLE: begin
                if (start_i) begin
                    ctx_d.pend = eff;
                    ctx_d.swz  = swizzle_i;
                    ctx_d.grp  = '0;
                    if (eff == '0) begin
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.st = QD_RUN;
                    end
                end
            end
            QD_RUN: begin
                if (ctx_q.swz) begin
                    ctx_d.iss   = 1'b1;
                    ctx_d.qidx  = ctx_q.grp;
                    ctx_d.lmask = pk_valid;
                    ctx_d.sel   = pk_sel;
                    ctx_d.pend  = pk_rest;
                    ctx_d.grp   = ctx_q.grp + 1'b1;
                    if (pk_rest == '0) begin
                        ctx_d.done = 1'b1;
                        ctx_d.st   = QD_IDLE;
                    end
                end else if (qp_found) begin
                    ctx_d.iss   = 1'b1;
                    ctx_d.qidx  = qp_idx;
                    ctx_d.lmask = qp_bits;
                    ctx_d.sel   = ident_sel;
                    ctx_d.pend  = qp_rest;
                    if (qp_rest == '0) begin
                        ctx_d.done = 1'b1;
                        ctx_d.st   = QD_IDLE;
                    end
                end else begin
                    ctx_d.st = QD_IDLE;
                end
            end
            default: ctx_d.st = QD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: QD_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    logic run_swz;
    assign run_swz = ctx_q.swz;

    assign ready_o = (ctx_q.st == QD_IDLE);
    assign issue_o = ctx_q.iss;
    assign quad_o  = ctx_q.qidx;
    assign lanes_o = ctx_q.lmask;
    assign sel_o   = ctx_q.sel;
    assign done_o  = ctx_q.done;

endmodule

// File: rtl/quad_dispatch_chk.sv
module quad_dispatch_chk #(
    parameter int LANES = 4,
    parameter int QW    = 3,
    parameter int TW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                ready_o,
    input logic                issue_o,
    input logic [QW-1:0]       quad_o,
    input logic [LANES-1:0]    lanes_o,
    input logic [LANES*TW-1:0] sel_o,
    input logic                done_o,
    input logic                swz
);
    logic ident_ok;
    logic pack_ok;

    always_comb begin
        ident_ok = 1'b1;
        for (int j = 0; j < LANES; j++) begin
            if (sel_o[j*TW +: TW] != TW'(int'(quad_o) * LANES + j)) ident_ok = 1'b0;
        end
        pack_ok = ((lanes_o & (lanes_o + 1'b1)) == '0);
        for (int j = 1; j < LANES; j++) begin
            if (lanes_o[j] && (sel_o[j*TW +: TW] <= sel_o[(j-1)*TW +: TW])) pack_ok = 1'b0;
        end
    end

    // R3
    issue_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> (lanes_o != '0));

    // R3
    quad_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && !swz && $past(issue_o) && !$past(done_o)) |-> (quad_o > $past(quad_o)));

    // R5
    quad_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && !swz) |-> ident_ok);

    // R6
    pack_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && swz) |-> pack_ok);

    // R9
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !done_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready_o) && !$past(start_i)) |-> !issue_o);

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !issue_o) |-> ($past(ready_o) && $past(start_i)));

endmodule

bind quad_dispatch quad_dispatch_chk #(
    .LANES (LANES),
    .QW    (QW),
    .TW    (TW)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_o (ready_o),
    .issue_o (issue_o),
    .quad_o  (quad_o),
    .lanes_o (lanes_o),
    .sel_o   (sel_o),
    .done_o  (done_o),
    .swz     (run_swz)
);

// File: tb/quad_dispatch_tb_top.sv
module quad_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  width_i = 2'd0;
    logic        swizzle_i = 1'b0;
    logic [31:0] exec_mask_i = '0;
    logic        ready_o, issue_o, done_o;
    logic [2:0]  quad_o;
    logic [3:0]  lanes_o;
    logic [19:0] sel_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
        .swizzle_i(swizzle_i), .exec_mask_i(exec_mask_i), .ready_o(ready_o),
        .issue_o(issue_o), .quad_o(quad_o), .lanes_o(lanes_o), .sel_o(sel_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected operation list
    int exp_q[8];
    int exp_l[8];
    int exp_s[8][4];
    int n_exp;

    task automatic build(input logic [1:0] w, input bit swz, input logic [31:0] m);
        int nt;
        int act_idx[32];
        int na;
        logic [31:0] eff;
        nt = 8 << w;
        if (nt > 32) nt = 32;
        eff = 0;
        for (int i = 0; i < nt; i++) eff[i] = m[i];
        n_exp = 0;
        if (!swz) begin
            for (int q = 0; q < nt / 4; q++) begin
                if (eff[4*q +: 4] != 0) begin
                    exp_q[n_exp] = q;
                    exp_l[n_exp] = int'(eff[4*q +: 4]);
                    for (int j = 0; j < 4; j++) exp_s[n_exp][j] = 4*q + j;
                    n_exp++;
                end
            end
        end else begin
            na = 0;
            for (int i = 0; i < 32; i++) if (eff[i]) begin act_idx[na] = i; na++; end
            for (int g = 0; g*4 < na; g++) begin
                exp_q[n_exp] = g;
                exp_l[n_exp] = 0;
                for (int j = 0; j < 4; j++) begin
                    if (g*4 + j < na) begin
                        exp_l[n_exp] |= (1 << j);
                        exp_s[n_exp][j] = act_idx[g*4 + j];
                    end else begin
                        exp_s[n_exp][j] = 0;
                    end
                end
                n_exp++;
            end
        end
    endtask

    task automatic run(input string req, input logic [1:0] w, input bit swz,
                       input logic [31:0] m, input bit interfere);
        logic [31:0] exp_sel;
        build(w, swz, m);
        width_i = w; swizzle_i = swz; exec_mask_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (n_exp == 0) begin
            // R8
            chk(done_o && !issue_o, req, "empty done after accept", {issue_o, done_o}, 32'h1);
            @(negedge clk);
            chk(!done_o && !issue_o && ready_o, req, "empty stays quiet", {ready_o, issue_o, done_o}, 32'h4);
            return;
        end
        // R7: nothing yet, busy
        chk(!issue_o && !ready_o && !done_o, "R7", "first cycle after accept",
            {ready_o, issue_o, done_o}, 32'h0);
        for (int k = 0; k < n_exp; k++) begin
            if (interfere && k == 0) begin
                start_i = 1'b1; width_i = 2'd2; swizzle_i = ~swz; exec_mask_i = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            start_i = 1'b0;
            exp_sel = 0;
            for (int j = 0; j < 4; j++) exp_sel[5*j +: 5] = exp_s[k][j][4:0];
            chk(issue_o === 1'b1, "R3", "issue without gap", {31'b0, issue_o}, 32'h1);
            chk(quad_o == exp_q[k][2:0], req, "quad index", {29'b0, quad_o}, exp_q[k]);
            chk(lanes_o == exp_l[k][3:0], req, "lane mask", {28'b0, lanes_o}, exp_l[k]);
            chk(sel_o == exp_sel[19:0], swz ? "R6" : "R5", "lane selects", {12'b0, sel_o}, exp_sel);
            if (k == n_exp - 1)
                chk(done_o && ready_o, "R7", "done with last op", {ready_o, done_o}, 32'h3);
            else
                chk(!done_o && !ready_o, "R7", "no early done", {ready_o, done_o}, 32'h0);
        end
        if (interfere) begin
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                // R9
                chk(!issue_o && !done_o && ready_o, "R9", "busy start ignored",
                    {ready_o, issue_o, done_o}, 32'h4);
            end
        end
    endtask

    task automatic t_reset();
        chk(ready_o && !issue_o && !done_o, "R1", "during reset", {ready_o, issue_o, done_o}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !issue_o && !done_o, "R1", "after reset", {ready_o, issue_o, done_o}, 32'h4);
    endtask

    task automatic t_dense16();  run("R3", 2'd1, 1'b0, 32'h0000_FFFF, 1'b0); endtask
    task automatic t_sparse16(); run("R4", 2'd1, 1'b0, 32'h0000_F0F0, 1'b0); endtask
    task automatic t_width8();   run("R2", 2'd0, 1'b0, 32'hFFFF_FF3C, 1'b0); endtask
    task automatic t_width32();  run("R2", 2'd2, 1'b0, 32'h8000_0001, 1'b0); endtask
    task automatic t_pack16();   run("R6", 2'd1, 1'b1, 32'h0000_F0F0, 1'b0); endtask
    task automatic t_pack32();   run("R6", 2'd3, 1'b1, 32'h1248_1001, 1'b0); endtask
    task automatic t_empty();
        run("R8", 2'd1, 1'b0, 32'h0000_0000, 1'b0);
        run("R8", 2'd0, 1'b1, 32'hFFFF_FF00, 1'b0);
    endtask
    task automatic t_busy();     run("R9", 2'd1, 1'b0, 32'h0000_0F0F, 1'b1); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_dense16();
        t_sparse16();
        t_width8();
        t_width32();
        t_pack16();
        t_pack32();
        t_empty();
        t_busy();
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule